// File: doc/BRIEF.md
# Word-to-Byte Bus Bridge

This bridge connects a processor that moves 16-bit words to two kinds of memory. The first is a fast region that is 16 bits wide. The second is a slow region of peripherals that is only 8 bits wide.

- **Fast region.** An access whose word address falls outside a configurable window is passed straight to the fast bus. It completes in two cycles, and the processor never waits.
- **Slow region.** An access inside the window is turned into two byte cycles on the narrow bus. The even byte goes first, then the odd byte. A read assembles the two bytes into one word. A write splits the word into two bytes. The processor is held in wait states meanwhile, and the whole access takes six cycles.

The processor has no byte-select line, so a slow access always runs both byte cycles. Every store arrives as a read of the address followed by a write to the same address. The bridge handles that as two independent, complete sequences.

The control is one state machine with seven states:

| State | Role |
|---|---|
| `ST_IDLE` | Accepts a request |
| `ST_FAST_DONE` | Data phase of a fast access |
| `ST_HI_SETUP` | Presents the even byte cycle |
| `ST_HI_STROBE` | Transfers and captures the even byte |
| `ST_LO_SETUP` | Presents the odd byte cycle |
| `ST_LO_STROBE` | Transfers and captures the odd byte |
| `ST_CONV_DONE` | Returns the assembled word |

The transitions are:

- `ST_IDLE` goes to `ST_FAST_DONE` on a request that misses the window.
- `ST_IDLE` goes to `ST_HI_SETUP` on a request that hits the window.
- `ST_IDLE` stays where it is when there is no request.
- The slow path advances one state per cycle: `ST_HI_SETUP`, `ST_HI_STROBE`, `ST_LO_SETUP`, `ST_LO_STROBE`, `ST_CONV_DONE`.
- Both `ST_FAST_DONE` and `ST_CONV_DONE` return to `ST_IDLE`.

Top module: `bus_narrow_bridge`

## Requirements
- R1: After reset the bridge is idle: `cpu_ready`=1, `cpu_done`=0, `nb_sel`=0, `nb_strobe`=0 and `fast_req`=0.
- R2: A request whose word address lies in [SLOW_BASE, SLOW_LIMIT] (inclusive) goes to the narrow bus only. Any other address goes to the fast bus only, with `fast_req` asserted in the request cycle.
- R3: A fast access completes with `cpu_done`=1 in the cycle after the request, with no wait state. `cpu_rdata` then equals the fast bus read data.
- R4: A slow access completes with `cpu_done`=1 exactly five cycles after the request cycle. `cpu_ready` is 0 for exactly the four cycles in between.
- R5: Each byte cycle lasts two cycles: setup with `nb_sel`=1, then strobe with `nb_sel`=1 and `nb_strobe`=1. The first byte cycle uses `nb_addr` bit 0 = 0 and the second uses bit 0 = 1. Bits [AW:1] of `nb_addr` equal the word address.
- R6: On a slow read, `cpu_rdata` = {byte read in the first strobe, byte read in the second strobe}.
- R7: On a slow write, both byte cycles always run with `nb_we`=1. The first carries `cpu_wdata[15:8]` and the second carries `cpu_wdata[7:0]`.
- R8: Requests made while a sequence is in progress are ignored. They cause no fast bus request, no extra byte cycle, and no change to the address or data being transferred.
- R9: A read followed directly by a write to the same slow address (one store) runs two complete sequences, and the written word is then read back unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| cpu_req | input | 1 | Access request, sampled while idle |
| cpu_we | input | 1 | 1 = write, 0 = read |
| cpu_addr | input | AW | Word address |
| cpu_wdata | input | DW | Write word |
| cpu_rdata | output | DW | Read word, valid when cpu_done=1 |
| cpu_ready | output | 1 | 0 while the processor must wait |
| cpu_done | output | 1 | Access completes this cycle |
| fast_req | output | 1 | Fast bus access strobe |
| fast_we | output | 1 | Fast bus write enable |
| fast_addr | output | AW | Fast bus word address |
| fast_wdata | output | DW | Fast bus write word |
| fast_rdata | input | DW | Fast bus read word, registered by the memory |
| nb_sel | output | 1 | Narrow byte cycle active |
| nb_strobe | output | 1 | Narrow transfer phase |
| nb_we | output | 1 | Narrow write enable |
| nb_addr | output | AW+1 | Narrow byte address |
| nb_wdata | output | DW/2 | Narrow write byte |
| nb_rdata | input | DW/2 | Narrow read byte, sampled at the end of a strobe |

## Verification
Counting the request cycle as cycle 1, results fall due as follows:

- A fast access finishes in cycle 2.
- A slow access shows its even strobe in cycle 3 and its odd strobe in cycle 5, and finishes in cycle 6.
- The processor waits during cycles 2 to 5.

The bench drives each request just after a falling edge. It then samples every following cycle at its falling edge, numbering the cycles. It compares the cycle in which `cpu_done` rises, the number of wait cycles, and the cycle and address of each strobe against those fixed positions. Stray requests are injected in cycle 3, and their effect is judged by the bus activity of that same access and by later read-back.

// File: rtl/bnb_pkg.sv
package bnb_pkg;

    typedef enum logic [2:0] {
        ST_IDLE      = 3'd0,
        ST_FAST_DONE = 3'd1,
        ST_HI_SETUP  = 3'd2,
        ST_HI_STROBE = 3'd3,
        ST_LO_SETUP  = 3'd4,
        ST_LO_STROBE = 3'd5,
        ST_CONV_DONE = 3'd6
    } bstate_t;

    localparam int LANES = 2;

endpackage

// File: rtl/bnb_region_decode.sv
module bnb_region_decode #(
    parameter int          AW    = 8,
    parameter logic [AW-1:0] BASE  = '0,
    parameter logic [AW-1:0] LIMIT = '1
) (
    input  logic [AW-1:0] addr,
    output logic          hit
);
    always_comb begin
        hit = (addr >= BASE) && (addr <= LIMIT);
    end
endmodule

// File: rtl/bnb_seq_fsm.sv
module bnb_seq_fsm
    import bnb_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic req,
    input  logic hit,
    output logic accept,
    output logic fast_go,
    output logic ready,
    output logic done,
    output logic from_narrow,
    output logic sel,
    output logic strobe,
    output logic lo_phase,
    output logic cap_hi,
    output logic cap_lo
);
    bstate_t state, state_nx;

    always_comb begin
        state_nx = state;
        unique case (state)
            ST_IDLE:      if (req) state_nx = hit ? ST_HI_SETUP : ST_FAST_DONE;
            ST_FAST_DONE: state_nx = ST_IDLE;
            ST_HI_SETUP:  state_nx = ST_HI_STROBE;
            ST_HI_STROBE: state_nx = ST_LO_SETUP;
            ST_LO_SETUP:  state_nx = ST_LO_STROBE;
            ST_LO_STROBE: state_nx = ST_CONV_DONE;
            ST_CONV_DONE: state_nx = ST_IDLE;
            default:      state_nx = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= state_nx;
    end

    always_comb begin
        accept      = 1'b0;
        fast_go     = 1'b0;
        ready       = 1'b0;
        done        = 1'b0;
        from_narrow = 1'b0;
        sel         = 1'b0;
        strobe      = 1'b0;
        lo_phase    = 1'b0;
        cap_hi      = 1'b0;
        cap_lo      = 1'b0;
        unique case (state)
            ST_IDLE: begin
                ready   = 1'b1;
                accept  = req;
                fast_go = req && !hit;
            end
            ST_FAST_DONE: begin
                ready = 1'b1;
                done  = 1'b1;
            end
            ST_HI_SETUP: begin
                sel = 1'b1;
            end
            ST_HI_STROBE: begin
                sel    = 1'b1;
                strobe = 1'b1;
                cap_hi = 1'b1;
            end
            ST_LO_SETUP: begin
                sel      = 1'b1;
                lo_phase = 1'b1;
            end
            ST_LO_STROBE: begin
                sel      = 1'b1;
                strobe   = 1'b1;
                lo_phase = 1'b1;
                cap_lo   = 1'b1;
            end
            ST_CONV_DONE: begin
                ready       = 1'b1;
                done        = 1'b1;
                from_narrow = 1'b1;
            end
            default: ;
        endcase
    end
endmodule

// File: rtl/bnb_data_steer.sv
module bnb_data_steer
    import bnb_pkg::*;
#(
    parameter int AW = 8,
    parameter int DW = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          load,
    input  logic          we_in,
    input  logic [AW-1:0] addr_in,
    input  logic [DW-1:0] wdata_in,
    input  logic          sel,
    input  logic          lo_phase,
    input  logic          cap_hi,
    input  logic          cap_lo,
    input  logic [DW/LANES-1:0] nb_rdata,
    output logic [AW:0]   nb_addr,
    output logic [DW/LANES-1:0] nb_wdata,
    output logic          nb_we,
    output logic [DW-1:0] word_rdata
);
    localparam int NW = DW / LANES;

    logic [AW-1:0] addr_q;
    logic [DW-1:0] wdata_q;
    logic          we_q;
    logic [LANES-1:0] cap;
    logic [NW-1:0] hold  [LANES];
    logic [NW-1:0] wlane [LANES];

    assign cap = {cap_lo, cap_hi};

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            addr_q  <= '0;
            wdata_q <= '0;
            we_q    <= 1'b0;
        end else if (load) begin
            addr_q  <= addr_in;
            wdata_q <= wdata_in;
            we_q    <= we_in;
        end
    end

    // lane 0 is the high-order (even) byte
    for (genvar i = 0; i < LANES; i++) begin : g_lane
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)      hold[i] <= '0;
            else if (cap[i]) hold[i] <= nb_rdata;
        end
        assign wlane[i] = wdata_q[DW-1-i*NW -: NW];
        assign word_rdata[DW-1-i*NW -: NW] = hold[i];
    end

    always_comb begin
        nb_addr  = {addr_q, lo_phase};
        nb_wdata = wlane[lo_phase];
        nb_we    = sel && we_q;
    end
endmodule

// File: rtl/bus_narrow_bridge.sv
module bus_narrow_bridge
    import bnb_pkg::*;
#(
    parameter int            AW         = 8,
    parameter int            DW         = 16,
    parameter logic [AW-1:0] SLOW_BASE  = 8'hC0,
    parameter logic [AW-1:0] SLOW_LIMIT = 8'hDF
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          cpu_req,
    input  logic          cpu_we,
    input  logic [AW-1:0] cpu_addr,
    input  logic [DW-1:0] cpu_wdata,
    output logic [DW-1:0] cpu_rdata,
    output logic          cpu_ready,
    output logic          cpu_done,
    output logic          fast_req,
    output logic          fast_we,
    output logic [AW-1:0] fast_addr,
    output logic [DW-1:0] fast_wdata,
    input  logic [DW-1:0] fast_rdata,
    output logic          nb_sel,
    output logic          nb_strobe,
    output logic          nb_we,
    output logic [AW:0]   nb_addr,
    output logic [DW/LANES-1:0] nb_wdata,
    input  logic [DW/LANES-1:0] nb_rdata
);
    logic hit, accept, fast_go, from_narrow, lo_phase, cap_hi, cap_lo;
    logic [DW-1:0] word_rdata;

    bnb_region_decode #(.AW(AW), .BASE(SLOW_BASE), .LIMIT(SLOW_LIMIT)) u_dec (
        .addr (cpu_addr),
        .hit  (hit)
    );

    bnb_seq_fsm u_fsm (
        .clk         (clk),
        .rst_n       (rst_n),
        .req         (cpu_req),
        .hit         (hit),
        .accept      (accept),
        .fast_go     (fast_go),
        .ready       (cpu_ready),
        .done        (cpu_done),
        .from_narrow (from_narrow),
        .sel         (nb_sel),
        .strobe      (nb_strobe),
        .lo_phase    (lo_phase),
        .cap_hi      (cap_hi),
        .cap_lo      (cap_lo)
    );

    bnb_data_steer #(.AW(AW), .DW(DW)) u_steer (
        .clk        (clk),
        .rst_n      (rst_n),
        .load       (accept && hit),
        .we_in      (cpu_we),
        .addr_in    (cpu_addr),
        .wdata_in   (cpu_wdata),
        .sel        (nb_sel),
        .lo_phase   (lo_phase),
        .cap_hi     (cap_hi),
        .cap_lo     (cap_lo),
        .nb_rdata   (nb_rdata),
        .nb_addr    (nb_addr),
        .nb_wdata   (nb_wdata),
        .nb_we      (nb_we),
        .word_rdata (word_rdata)
    );

    always_comb begin
        fast_req   = fast_go;
        fast_we    = fast_go && cpu_we;
        fast_addr  = cpu_addr;
        fast_wdata = cpu_wdata;
        cpu_rdata  = from_narrow ? word_rdata : fast_rdata;
    end
endmodule

// File: rtl/bnb_checker.sv
module bnb_checker #(
    parameter int AW = 8
) (
    input logic        clk,
    input logic        rst_n,
    input logic        cpu_ready,
    input logic        cpu_done,
    input logic        fast_req,
    input logic        nb_sel,
    input logic        nb_strobe,
    input logic [AW:0] nb_addr
);
    logic [3:0] wait_run;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)         wait_run <= '0;
        else if (cpu_ready) wait_run <= '0;
        else                wait_run <= wait_run + 4'd1;
    end

    p_fast_done_r3: assert property (@(posedge clk) disable iff (!rst_n)
        fast_req |=> cpu_done && cpu_ready);

    p_wait_len_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (cpu_ready && wait_run != 4'd0) |-> (wait_run == 4'd4 && cpu_done));

    p_lo_then_done_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (nb_strobe && nb_addr[0]) |=> (cpu_done && !nb_sel));

    p_hi_then_lo_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (nb_strobe && !nb_addr[0]) |=> (nb_sel && !nb_strobe && nb_addr[0]));

    p_addr_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (nb_sel && $past(nb_sel)) |-> $stable(nb_addr[AW:1]));

    p_busy_quiet_r8: assert property (@(posedge clk) disable iff (!rst_n)
        !cpu_ready |-> (!fast_req && !cpu_done));

    p_sel_waits_r7: assert property (@(posedge clk) disable iff (!rst_n)
        nb_sel |-> !cpu_ready);
endmodule

bind bus_narrow_bridge bnb_checker #(.AW(AW)) u_bnb_checker (
    .clk       (clk),
    .rst_n     (rst_n),
    .cpu_ready (cpu_ready),
    .cpu_done  (cpu_done),
    .fast_req  (fast_req),
    .nb_sel    (nb_sel),
    .nb_strobe (nb_strobe),
    .nb_addr   (nb_addr)
);

// File: tb/test_bus_narrow_bridge.sv
`timescale 1ns/1ps
module test_bus_narrow_bridge;
    localparam int            AW    = 4;
    localparam int            DW    = 16;
    localparam logic [AW-1:0] BASE  = 4'h8;
    localparam logic [AW-1:0] LIMIT = 4'hB;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    always #2 clk = ~clk;

    logic          cpu_req = 1'b0, cpu_we = 1'b0;
    logic [AW-1:0] cpu_addr = '0;
    logic [DW-1:0] cpu_wdata = '0;
    logic [DW-1:0] cpu_rdata, fast_wdata, fast_rdata;
    logic          cpu_ready, cpu_done, fast_req, fast_we;
    logic [AW-1:0] fast_addr;
    logic          nb_sel, nb_strobe, nb_we;
    logic [AW:0]   nb_addr;
    logic [7:0]    nb_wdata, nb_rdata;

    bus_narrow_bridge #(.AW(AW), .DW(DW), .SLOW_BASE(BASE), .SLOW_LIMIT(LIMIT)) i_bus_narrow_bridge (
        .clk(clk), .rst_n(rst_n), .cpu_req(cpu_req), .cpu_we(cpu_we),
        .cpu_addr(cpu_addr), .cpu_wdata(cpu_wdata), .cpu_rdata(cpu_rdata),
        .cpu_ready(cpu_ready), .cpu_done(cpu_done), .fast_req(fast_req),
        .fast_we(fast_we), .fast_addr(fast_addr), .fast_wdata(fast_wdata),
        .fast_rdata(fast_rdata), .nb_sel(nb_sel), .nb_strobe(nb_strobe),
        .nb_we(nb_we), .nb_addr(nb_addr), .nb_wdata(nb_wdata), .nb_rdata(nb_rdata)
    );

    function automatic logic [15:0] init_word(input int k);
        return 16'(k * 16'h0707 + 16'h1234);
    endfunction

    // memory models
    logic [15:0] fmem [16];
    logic [7:0]  pmem [32];
    logic [15:0] fq;
    initial begin
        for (int k = 0; k < 16; k++) begin
            fmem[k]       = init_word(k);
            pmem[2*k]     = init_word(k)[15:8];
            pmem[2*k + 1] = init_word(k)[7:0];
        end
    end
    always @(posedge clk) begin
        if (fast_req) begin
            if (fast_we) fmem[fast_addr] <= fast_wdata;
            fq <= fmem[fast_addr];
        end
        if (nb_strobe && nb_we) pmem[nb_addr] <= nb_wdata;
    end
    assign fast_rdata = fq;
    assign nb_rdata   = pmem[nb_addr];

    // expected contents, kept by the bench
    logic [15:0] shadow [16];
    initial for (int k = 0; k < 16; k++) shadow[k] = init_word(k);

    int checks = 0, fails = 0;

    task automatic check(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    // results of the last access
    int          cyc_done, waits, fasts, nstr;
    logic [AW:0] s_addr [4];
    logic [7:0]  s_dat  [4];
    logic [15:0] got;

    task automatic access(input bit we, input logic [AW-1:0] a, input logic [15:0] wd,
                          input bit glitch, input logic [AW-1:0] ga);
        int cyc;
        @(negedge clk);
        cpu_req = 1'b1; cpu_we = we; cpu_addr = a; cpu_wdata = wd;
        cyc = 1; waits = 0; fasts = 0; nstr = 0; cyc_done = 0; got = '0;
        #1;
        if (fast_req) fasts++;
        while (cyc_done == 0 && cyc < 12) begin
            @(negedge clk);
            cyc++;
            cpu_req = 1'b0;
            if (glitch && cyc == 3) begin
                cpu_req = 1'b1; cpu_we = 1'b1; cpu_addr = ga; cpu_wdata = 16'hDEAD;
            end
            #1;
            if (fast_req) fasts++;
            if (!cpu_ready) waits++;
            if (nb_strobe && nstr < 4) begin
                s_addr[nstr] = nb_addr;
                s_dat[nstr]  = nb_we ? nb_wdata : 8'h00;
                nstr++;
            end
            if (cpu_done) begin
                cyc_done = cyc;
                got = cpu_rdata;
            end
        end
        cpu_req = 1'b0;
    endtask

    task automatic verify(input bit we, input logic [AW-1:0] a, input logic [15:0] wd, input bit stray);
        bit slow = (a >= BASE) && (a <= LIMIT);
        if (slow) begin
            check(cyc_done == 6, "R4 done cycle", 32'(cyc_done), 6);
            check(waits == 4, "R4 wait cycles", 32'(waits), 4);
            check(fasts == 0, stray ? "R8 stray fast req" : "R2 no fast req on slow", 32'(fasts), 0);
            check(nstr == 2, stray ? "R8 stray byte cycles" : "R7 two byte cycles", 32'(nstr), 2);
            check(s_addr[0] == {a, 1'b0}, "R5 first byte addr", 32'(s_addr[0]), 32'({a, 1'b0}));
            check(s_addr[1] == {a, 1'b1}, "R5 second byte addr", 32'(s_addr[1]), 32'({a, 1'b1}));
            if (we) begin
                check(s_dat[0] == wd[15:8], "R7 first byte data", 32'(s_dat[0]), 32'(wd[15:8]));
                check(s_dat[1] == wd[7:0], "R7 second byte data", 32'(s_dat[1]), 32'(wd[7:0]));
            end else begin
                check(got == shadow[a], "R6 assembled word", 32'(got), 32'(shadow[a]));
            end
        end else begin
            check(cyc_done == 2, "R3 fast done cycle", 32'(cyc_done), 2);
            check(waits == 0, "R3 no waits", 32'(waits), 0);
            check(fasts == 1, "R2 fast req", 32'(fasts), 1);
            check(nstr == 0, "R2 no byte cycles on fast", 32'(nstr), 0);
            if (!we) check(got == shadow[a], "R3 fast read data", 32'(got), 32'(shadow[a]));
        end
        if (we) shadow[a] = wd;
    endtask

    task automatic run_all();
        repeat (3) @(negedge clk);
        check(cpu_ready == 1'b1, "R1 ready", 32'(cpu_ready), 1);
        check(cpu_done == 1'b0, "R1 done", 32'(cpu_done), 0);
        check(nb_sel == 1'b0 && nb_strobe == 1'b0, "R1 narrow idle", 32'({nb_sel, nb_strobe}), 0);
        check(fast_req == 1'b0, "R1 fast idle", 32'(fast_req), 0);
        @(negedge clk) rst_n = 1'b1;
        repeat (2) @(negedge clk);
        // store sweep: read then write (R9), then read back
        for (int a = 0; a < 16; a++) begin
            logic [15:0] w = 16'(a * 16'h1357) ^ 16'hC0DE;
            access(1'b0, 4'(a), '0, 1'b0, '0);   verify(1'b0, 4'(a), '0, 1'b0);
            access(1'b1, 4'(a), w, 1'b0, '0);    verify(1'b1, 4'(a), w, 1'b0);
            access(1'b0, 4'(a), '0, 1'b0, '0);   verify(1'b0, 4'(a), '0, 1'b0);
            check(got == w, "R9 store read-back", 32'(got), 32'(w));
        end
        // R8: stray request to a fast address during a slow read
        access(1'b0, 4'h9, '0, 1'b1, 4'h2); verify(1'b0, 4'h9, '0, 1'b1);
        access(1'b0, 4'h2, '0, 1'b0, '0);   verify(1'b0, 4'h2, '0, 1'b0);
        check(got == shadow[2], "R8 fast word untouched", 32'(got), 32'(shadow[2]));
        // R8: stray request to another slow address during a slow write
        access(1'b1, 4'hA, 16'h5AA5, 1'b1, 4'hB); verify(1'b1, 4'hA, 16'h5AA5, 1'b1);
        access(1'b0, 4'hB, '0, 1'b0, '0);          verify(1'b0, 4'hB, '0, 1'b0);
        check(got == shadow[11], "R8 slow word untouched", 32'(got), 32'(shadow[11]));
    endtask

    initial begin
        fork
            run_all();
            begin
                repeat (150000) @(posedge clk);
                checks++; fails++;
                $display("FAIL watchdog expired actual=hung expected=finished");
            end
        join_any
        disable fork;
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end
endmodule